// File: doc/BRIEF.md
# Virtual Address Translation Controller

This block turns one virtual memory access into a physical address, or into an access fault. A requester presents a virtual address, the kind of access (instruction fetch, data load or data store) and the processor's privilege state. The controller works out which privilege mode governs the access. That mode decides whether the address passes through untranslated or goes through the page tables.

For an untranslated access the result is the address clipped to the configured register width. For a translated access the controller asks an external page-table walker. The request carries the address, the access kind, whether the mode is above user, and whether user-page protection applies. The controller then joins the returned physical page with the page offset of the virtual address. If the walker returns the all-ones failure marker, the controller reports an access fault of the matching kind instead.

Only one access is in flight at a time. The privilege state is sampled when a request is accepted. The result is held until the consumer takes it.

Top module: `vat_ctrl`

## Requirements
- R1: A fetch (`req_kind`=0) is governed by `cur_priv` alone; `mprv_en` and `prev_priv` have no effect on it. Privilege codes are user=0, supervisor=1, machine=3.
- R2: For a load (`req_kind`=1) or store (`req_kind`=2), `prev_priv` replaces `cur_priv` when `mprv_en`=1 and `dbg_mode`=0. When `dbg_mode`=1, `cur_priv` is used.
- R3: `walk_umprot` is 1 only for a non-fetch access whose governing mode is supervisor while `umprot_en`=1; otherwise it is 0.
- R4: When `vm_mode` is zero (bare), the governing mode is forced to machine, whatever the other privilege inputs are.
- R5: When the governing mode is machine, no walker request is issued. `res_addr` is `req_vaddr` with every bit at or above XLEN cleared, and `res_cause`=0.
- R6: On a successful walk, `res_addr` is the walker's address with its low PAGE_SHIFT bits replaced by those of the virtual address, and `res_cause`=0.
- R7: A walker result of all ones is a fault unless the virtual address is also all ones. On a fault, `res_cause` is 1 for a fetch, 2 for a load and 3 for a store, and `res_addr` carries the faulting virtual address. In the all-ones exception, the result is the all-ones address with `res_cause`=0.
- R8: `walk_super` is 1 whenever the governing mode of a walked access is above user.
- R9: `req_ready` stays low from acceptance until the result is taken. `res_addr` and `res_cause` stay stable while `res_valid`=1 and `res_ready`=0.
- R10: A walker request stays asserted with a stable address and kind until `walk_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_vaddr | input | ADDR_W | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store (3 treated as load) |
| cur_priv | input | 2 | Current privilege mode |
| prev_priv | input | 2 | Previous privilege mode field |
| mprv_en | input | 1 | Data accesses use the previous privilege |
| dbg_mode | input | 1 | Processor is in debug mode |
| umprot_en | input | 1 | Supervisor may not touch user pages |
| vm_mode | input | VM_W | Translation scheme; zero means bare |
| walk_valid | output | 1 | Walker request present |
| walk_ready | input | 1 | Walker accepts the request |
| walk_vaddr | output | ADDR_W | Address to walk |
| walk_kind | output | 2 | Access kind for permission checking |
| walk_super | output | 1 | Governing mode is above user |
| walk_umprot | output | 1 | User-page protection applies |
| walk_rsp_valid | input | 1 | Walker result present |
| walk_rsp_paddr | input | ADDR_W | Page-aligned physical address, all ones on failure |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_addr | output | ADDR_W | Physical address, or faulting virtual address |
| res_cause | output | 2 | 0 none, 1 fetch fault, 2 load fault, 3 store fault |

## Verification
The hardest case to reach is the one where a data access takes its mode from the previous-privilege field. When that field is machine, the access must skip the walker entirely, even though the current mode would have walked. When debug mode is set, the same inputs must fall back to the current mode. The stimulus builds these cases by setting the privilege inputs in contrasting combinations for the same address. A walker model fails any request that the scoreboard did not predict, so a missing or extra walk shows up as a reported failure. Separate cases hold back `walk_ready` and `res_ready` for several cycles, so the held values can be compared while they wait.

// File: rtl/vat_pkg.sv
package vat_pkg;
  typedef enum logic [1:0] {PRIV_U = 2'd0, PRIV_S = 2'd1, PRIV_H = 2'd2, PRIV_M = 2'd3} priv_e;
  typedef enum logic [1:0] {ACC_FETCH = 2'd0, ACC_LOAD = 2'd1, ACC_STORE = 2'd2, ACC_OTHER = 2'd3} acc_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_FETCH = 2'd1, FLT_LOAD = 2'd2, FLT_STORE = 2'd3} flt_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WALK = 2'd1, ST_WAIT = 2'd2, ST_DONE = 2'd3} st_e;
endpackage

// File: rtl/vat_mode_sel.sv
module vat_mode_sel
  import vat_pkg::*;
#(
  parameter int VM_W = 4
) (
  input  logic [1:0]      kind,
  input  logic [1:0]      cur_priv,
  input  logic [1:0]      prev_priv,
  input  logic            mprv_en,
  input  logic            dbg_mode,
  input  logic            umprot_en,
  input  logic [VM_W-1:0] vm_mode,
  output logic            bypass,
  output logic            is_super,
  output logic            umprot
);
  logic [1:0] mode;

  always_comb begin
    mode   = cur_priv;
    umprot = 1'b0;
    if (acc_e'(kind) != ACC_FETCH) begin
      if (mprv_en && !dbg_mode) mode = prev_priv;
      umprot = (priv_e'(mode) == PRIV_S) && umprot_en;
    end
    if (vm_mode == '0) mode = PRIV_M;
    bypass   = (priv_e'(mode) == PRIV_M);
    is_super = (priv_e'(mode) != PRIV_U);
  end
endmodule

// File: rtl/vat_result_fmt.sv
module vat_result_fmt
  import vat_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int XLEN       = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] rsp_paddr,
  input  logic [1:0]        kind,
  input  logic              bypass,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        cause,
  output logic              walk_fail
);
  function automatic logic [ADDR_W-1:0] ones_below(input int n);
    logic [ADDR_W-1:0] m;
    for (int i = 0; i < ADDR_W; i++) m[i] = (i < n);
    return m;
  endfunction

  function automatic logic [ADDR_W-1:0] clip_xlen(input logic [ADDR_W-1:0] a);
    return a & ones_below(XLEN);
  endfunction

  function automatic logic [ADDR_W-1:0] join_page(input logic [ADDR_W-1:0] page,
                                                  input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off_m;
    off_m = ones_below(PAGE_SHIFT);
    return (page & ~off_m) | (a & off_m);
  endfunction

  function automatic logic [1:0] fault_of(input logic [1:0] k);
    case (acc_e'(k))
      ACC_FETCH: return FLT_FETCH;
      ACC_STORE: return FLT_STORE;
      default:   return FLT_LOAD;
    endcase
  endfunction

  always_comb begin
    walk_fail = (&rsp_paddr) && !(&vaddr);
    if (bypass) begin
      addr  = clip_xlen(vaddr);
      cause = FLT_NONE;
    end else if (walk_fail) begin
      addr  = vaddr;
      cause = fault_of(kind);
    end else begin
      addr  = join_page(rsp_paddr, vaddr);
      cause = FLT_NONE;
    end
  end
endmodule

// File: rtl/vat_ctrl.sv
module vat_ctrl
  import vat_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int XLEN       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int VM_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        cur_priv,
  input  logic [1:0]        prev_priv,
  input  logic              mprv_en,
  input  logic              dbg_mode,
  input  logic              umprot_en,
  input  logic [VM_W-1:0]   vm_mode,
  output logic              walk_valid,
  input  logic              walk_ready,
  output logic [ADDR_W-1:0] walk_vaddr,
  output logic [1:0]        walk_kind,
  output logic              walk_super,
  output logic              walk_umprot,
  input  logic              walk_rsp_valid,
  input  logic [ADDR_W-1:0] walk_rsp_paddr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_addr,
  output logic [1:0]        res_cause
);
  st_e               st;
  logic [ADDR_W-1:0] r_vaddr;
  logic [1:0]        r_kind;
  logic              r_super, r_ump;
  logic [ADDR_W-1:0] r_res_addr;
  logic [1:0]        r_res_cause;

  // named internal events
  logic              ev_accept, ev_walk_sent, ev_walk_back, ev_taken;
  logic              sel_bypass, sel_super, sel_ump;
  logic              fmt_idle, fmt_fail;
  logic [ADDR_W-1:0] fmt_vaddr, fmt_addr;
  logic [1:0]        fmt_kind, fmt_cause;

  vat_mode_sel #(.VM_W(VM_W)) i_mode (
    .kind(req_kind), .cur_priv(cur_priv), .prev_priv(prev_priv),
    .mprv_en(mprv_en), .dbg_mode(dbg_mode), .umprot_en(umprot_en),
    .vm_mode(vm_mode), .bypass(sel_bypass), .is_super(sel_super), .umprot(sel_ump)
  );

  assign fmt_idle  = (st == ST_IDLE);
  assign fmt_vaddr = fmt_idle ? req_vaddr : r_vaddr;
  assign fmt_kind  = fmt_idle ? req_kind : r_kind;

  vat_result_fmt #(.ADDR_W(ADDR_W), .XLEN(XLEN), .PAGE_SHIFT(PAGE_SHIFT)) i_fmt (
    .vaddr(fmt_vaddr), .rsp_paddr(walk_rsp_paddr), .kind(fmt_kind),
    .bypass(fmt_idle), .addr(fmt_addr), .cause(fmt_cause), .walk_fail(fmt_fail)
  );

  assign req_ready    = (st == ST_IDLE);
  assign walk_valid   = (st == ST_WALK);
  assign res_valid    = (st == ST_DONE);
  assign ev_accept    = req_valid && req_ready;
  assign ev_walk_sent = walk_valid && walk_ready;
  assign ev_walk_back = (st == ST_WAIT) && walk_rsp_valid;
  assign ev_taken     = res_valid && res_ready;

  assign walk_vaddr  = r_vaddr;
  assign walk_kind   = r_kind;
  assign walk_super  = r_super;
  assign walk_umprot = r_ump;
  assign res_addr    = r_res_addr;
  assign res_cause   = r_res_cause;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      r_vaddr     <= '0;
      r_kind      <= '0;
      r_super     <= 1'b0;
      r_ump       <= 1'b0;
      r_res_addr  <= '0;
      r_res_cause <= '0;
    end else begin
      case (st)
        ST_IDLE: if (ev_accept) begin
          r_vaddr <= req_vaddr;
          r_kind  <= req_kind;
          r_super <= sel_super;
          r_ump   <= sel_ump;
          if (sel_bypass) begin
            r_res_addr  <= fmt_addr;
            r_res_cause <= fmt_cause;
            st          <= ST_DONE;
          end else begin
            st <= ST_WALK;
          end
        end
        ST_WALK: if (ev_walk_sent) st <= ST_WAIT;
        ST_WAIT: if (ev_walk_back) begin
          r_res_addr  <= fmt_addr;
          r_res_cause <= fmt_cause;
          st          <= ST_DONE;
        end
        default: if (ev_taken) st <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!res_valid && !walk_valid)); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_addr) && $stable(res_cause))); // R9
  AST_WALK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_valid && !walk_ready) |=> (walk_valid && $stable(walk_vaddr) && $stable(walk_kind))); // R10
  AST_FETCH_NO_UMPROT: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_valid && walk_kind == 2'd0) |-> !walk_umprot); // R3
  AST_UMPROT_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_valid && walk_umprot) |-> walk_super); // R8
  AST_FAIL_IS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_walk_back && fmt_fail) |=> (res_valid && res_cause != 2'd0)); // R7
endmodule

// File: tb/test_vat_ctrl.sv
`timescale 1ns/1ps
module test_vat_ctrl;
  localparam int AW = 64;
  localparam int XL = 32;
  localparam logic [AW-1:0] OFFM = 64'hFFF;

  logic          clk = 0, rst_n = 0;
  logic          req_valid = 0, req_ready;
  logic [AW-1:0] req_vaddr = '0;
  logic [1:0]    req_kind = '0, cur_priv = '0, prev_priv = '0;
  logic          mprv_en = 0, dbg_mode = 0, umprot_en = 0;
  logic [3:0]    vm_mode = '0;
  logic          walk_valid, walk_ready = 0, walk_super, walk_umprot;
  logic [AW-1:0] walk_vaddr;
  logic [1:0]    walk_kind;
  logic          walk_rsp_valid = 0;
  logic [AW-1:0] walk_rsp_paddr = '0;
  logic          res_valid, res_ready = 0;
  logic [AW-1:0] res_addr;
  logic [1:0]    res_cause;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  vat_ctrl i_vat_ctrl (.*);

  typedef struct { logic [AW-1:0] addr; logic [1:0] cause; int stall; string tag; } res_t;
  typedef struct { logic [AW-1:0] va; logic [1:0] kind; logic sup; logic ump;
                   logic [AW-1:0] rsp; int stall; string tag; } walk_t;
  res_t  resq[$];
  walk_t wq[$];

  task automatic check(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // walker model
  walk_t wcur;
  bit    w_active = 0, rsp_due = 0;
  int    w_left = 0;
  logic [AW-1:0] rsp_val;
  always @(negedge clk) begin
    walk_rsp_valid = 0;
    if (rsp_due) begin walk_rsp_valid = 1; walk_rsp_paddr = rsp_val; rsp_due = 0; end
    walk_ready = 0;
    if (rst_n && walk_valid) begin
      if (!w_active) begin
        if (wq.size() == 0) check(0, "R5 unexpected walk", walk_vaddr, '0);
        else begin
          wcur = wq[0]; w_active = 1; w_left = wcur.stall;
          check(walk_super == wcur.sup, {wcur.tag, " walk_super"}, AW'(walk_super), AW'(wcur.sup));
          check(walk_umprot == wcur.ump, {wcur.tag, " walk_umprot"}, AW'(walk_umprot), AW'(wcur.ump));
          check(walk_kind == wcur.kind, {wcur.tag, " walk_kind"}, AW'(walk_kind), AW'(wcur.kind));
        end
      end
      if (w_active) begin
        check(walk_vaddr == wcur.va, "R10 walk address", walk_vaddr, wcur.va);
        if (w_left == 0) begin
          walk_ready = 1; rsp_due = 1; rsp_val = wcur.rsp;
          void'(wq.pop_front()); w_active = 0;
        end else w_left--;
      end
    end
  end

  // result monitor
  bit m_started = 0;
  int m_left = 0;
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      check(req_ready == 0, "R9 busy", AW'(req_ready), '0);
      if (resq.size() == 0) check(0, "R9 unexpected result", res_addr, '0);
      else begin
        check(res_addr == resq[0].addr, {resq[0].tag, " addr"}, res_addr, resq[0].addr);
        check(res_cause == resq[0].cause, {resq[0].tag, " cause"}, AW'(res_cause), AW'(resq[0].cause));
        if (!m_started) begin m_left = resq[0].stall; m_started = 1; end
        if (m_left == 0) begin res_ready = 1; void'(resq.pop_front()); m_started = 0; end
        else begin res_ready = 0; m_left--; end
      end
    end else res_ready = 0;
  end

  task automatic do_req(input logic [AW-1:0] va, input logic [1:0] kind, input logic [1:0] cur,
                        input logic [1:0] prev, input bit mprv, input bit dbg, input bit ubit,
                        input logic [3:0] vm, input logic [AW-1:0] rsp, input int wstall,
                        input int rstall, input string tag);
    logic [1:0] eff;
    bit ump, byp, fail;
    res_t r;
    walk_t w;
    eff = cur;
    if (kind != 2'd0 && mprv && !dbg) eff = prev;
    ump = (kind != 2'd0) && (eff == 2'd1) && ubit;
    if (vm == 0) eff = 2'd3;
    byp = (eff == 2'd3);
    fail = (rsp == '1) && (va != '1);
    r.tag = tag; r.stall = rstall;
    if (byp) begin r.addr = {32'h0, va[31:0]}; r.cause = 0; end
    else if (fail) begin r.addr = va; r.cause = (kind == 0) ? 2'd1 : (kind == 2) ? 2'd3 : 2'd2; end
    else begin r.addr = (rsp & ~OFFM) | (va & OFFM); r.cause = 0; end
    resq.push_back(r);
    if (!byp) begin
      w.va = va; w.kind = kind; w.sup = (eff != 0); w.ump = ump; w.rsp = rsp;
      w.stall = wstall; w.tag = tag;
      wq.push_back(w);
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_vaddr = va; req_kind = kind; cur_priv = cur; prev_priv = prev;
    mprv_en = mprv; dbg_mode = dbg; umprot_en = ubit; vm_mode = vm;
    @(negedge clk);
    req_valid = 0;
    while (resq.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R9 reset ready", AW'(req_ready), 1);
    check(walk_valid == 0, "R10 reset walk", AW'(walk_valid), 0);
    check(res_valid == 0, "R9 reset result", AW'(res_valid), 0);
    // R5 machine mode clips to XLEN
    do_req(64'hFFFF_FFFF_1234_5678, 2'd1, 2'd3, 2'd0, 0, 0, 0, 4'd8, '0, 0, 0, "R5 machine");
    // R4 bare forces machine
    do_req(64'hABCD_0000_0000_0F00, 2'd0, 2'd0, 2'd0, 0, 0, 1, 4'd0, '0, 0, 0, "R4 bare");
    // R1 fetch ignores mprv/prev; R6 join
    do_req(64'h0000_0000_0040_1234, 2'd0, 2'd0, 2'd3, 1, 0, 1, 4'd8, 64'h8000_0000_0000_0ABC, 0, 0, "R1 R6 fetch user");
    // R2 R3 load via prev=S with protection
    do_req(64'h0000_0000_7000_0008, 2'd1, 2'd0, 2'd1, 1, 0, 1, 4'd8, 64'h0000_0012_3456_7000, 0, 0, "R2 R3 prevS");
    // R2 debug mode falls back to current
    do_req(64'h0000_0000_7000_0008, 2'd1, 2'd0, 2'd1, 1, 1, 1, 4'd8, 64'h0000_0012_3456_7000, 0, 0, "R2 debug");
    // R2 store from machine with prev=U walks
    do_req(64'h0000_0000_0000_2FFC, 2'd2, 2'd3, 2'd0, 1, 0, 0, 4'd8, 64'h0000_0000_0009_9000, 0, 0, "R2 store prevU");
    // R2 R5 prev=M skips walk although current is S
    do_req(64'hFFFF_0000_8000_0010, 2'd1, 2'd1, 2'd3, 1, 0, 0, 4'd8, '0, 0, 0, "R2 R5 prevM");
    // R3 fetch in S never protected
    do_req(64'h0000_0000_0001_0004, 2'd0, 2'd1, 2'd1, 0, 0, 1, 4'd8, 64'h0000_0000_0044_4000, 0, 0, "R3 fetch S");
    // R8 load in S without protection
    do_req(64'h0000_0000_0001_0FF8, 2'd1, 2'd1, 2'd0, 0, 0, 0, 4'd8, 64'h0000_0000_0055_5FFF, 0, 0, "R8 load S");
    // R7 faults of each kind
    do_req(64'h0000_0000_0000_1000, 2'd1, 2'd1, 2'd0, 0, 0, 0, 4'd8, '1, 0, 0, "R7 load fault");
    do_req(64'h0000_0000_0000_2000, 2'd2, 2'd0, 2'd0, 0, 0, 0, 4'd8, '1, 0, 0, "R7 store fault");
    do_req(64'h0000_0000_0000_3000, 2'd0, 2'd1, 2'd0, 0, 0, 0, 4'd8, '1, 0, 0, "R7 fetch fault");
    do_req('1, 2'd1, 2'd1, 2'd0, 0, 0, 0, 4'd8, '1, 0, 0, "R7 all ones exception");
    // R9 R10 stalls on both handshakes
    do_req(64'h0000_0000_0ABC_DEF0, 2'd2, 2'd1, 2'd0, 0, 0, 1, 4'd8, 64'h0000_0000_1111_1000, 3, 4, "R9 R10 stalls");
    do_req(64'h0000_0000_1234_5678, 2'd1, 2'd3, 2'd0, 0, 0, 0, 4'd8, '0, 0, 3, "R9 bypass stall");
    repeat (3) @(negedge clk);
    check(req_ready == 1, "R9 idle after run", AW'(req_ready), 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule